// File: doc/BRIEF.md
# Wavefront Allocator

This block matches N requesters to N resources in a single combinational pass. Each requester presents a row of request bits, one per resource, and the block returns a grant matrix in which every row and every column carries at most one grant. Conflicts between requesters and conflicts between resources are settled together, by tokens that sweep across a square array of cells, rather than by a bank of row arbiters followed by a bank of column arbiters.

Each row and each column owns one token. All tokens start at the cells of one diagonal, the priority diagonal. A cell that requests and holds both its row token and its column token takes the grant and retires both tokens. Otherwise it hands its row token to the cell on its right and its column token to the cell below, wrapping at the array edges, so the tokens advance one diagonal per step until every diagonal has been visited. The priority diagonal advances by one every clock so that no cell keeps a standing advantage. The array is built with the wrap-around loop cut at the priority diagonal, which leaves an acyclic chain of N steps.

Top module: `wave_alloc`

## Requirements
- R1: No row of `gnt_o` has more than one bit set. Bit `i*N+j` of `req_i` and of `gnt_o` belongs to requester row i and resource column j.
- R2: No column of `gnt_o` has more than one bit set.
- R3: A grant bit is set only where the matching request bit is set.
- R4: The matching is maximal: no cell requests while both its row and its column are left without any grant.
- R5: Every requesting cell on the priority diagonal, the cells (i,j) with (i+j) mod N equal to the pointer, is granted.
- R6: The grants equal those of the token model: row and column tokens start on the priority diagonal, diagonal (p+s) mod N is visited at step s, a requesting cell holding both tokens is granted and retires them, and otherwise the row token moves to column (j+1) mod N and the column token to row (i+1) mod N.
- R7: While `rst_n` is low and on the first cycle after release, the pointer is 0; with rows asking for {0,1,2}, {0,1}, {0} and {0,2}, the grants are cells (0,0), (1,1) and (3,2).
- R8: On each rising clock edge with `rst_n` high, the pointer advances by one, and from N-1 it returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the priority pointer advances on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the pointer to diagonal 0 |
| req_i | input | N*N | Request matrix, bit i*N+j is row i asking for column j |
| gnt_o | output | N*N | Grant matrix, same bit layout as req_i |

## Verification
The hardest situation to reach is a token that travels all the way round the wrap-around edge before being used, since that happens only when several requests near the priority diagonal are blocked and a distant cell in the same row or column is the only remaining taker, and it has to happen at every pointer position. The bench sweeps every one of the 65536 request patterns of the 4-by-4 configuration while the pointer keeps rotating, so each pattern meets a known pointer value and every long wrapped path appears, and compares each result with a token model written as row and column liveness flags. An all-ones request makes the grant equal to the priority diagonal, which exposes the pointer itself for the rotation check.

// File: rtl/wa_pkg.sv
package wa_pkg;

  // Column reached by a token of row `row` after `step` hops when the
  // sweep starts on diagonal `prio` of an n-by-n array.
  function automatic int unsigned step_to_col(int unsigned row, int unsigned step,
                                              int unsigned prio, int unsigned n);
    return (prio + step + n - row) % n;
  endfunction

  // Inverse mapping: which hop of row `row` lands on column `col`.
  function automatic int unsigned col_to_step(int unsigned row, int unsigned col,
                                              int unsigned prio, int unsigned n);
    return (col + row + n - prio) % n;
  endfunction

  // Pointer successor with wrap at n.
  function automatic int unsigned prio_succ(int unsigned prio, int unsigned n);
    return (prio + 1 == n) ? 0 : prio + 1;
  endfunction

endpackage

// File: rtl/wa_cell.sv
module wa_cell (
  input  logic want_i,
  input  logic row_tok_i,
  input  logic col_tok_i,
  output logic win_o,
  output logic row_tok_o,
  output logic col_tok_o
);
  // A cell wins only when it asks and both tokens are present; a win
  // retires both tokens, otherwise they move on unchanged.
  assign win_o     = want_i & row_tok_i & col_tok_i;
  assign row_tok_o = row_tok_i & ~win_o;
  assign col_tok_o = col_tok_i & ~win_o;
endmodule

// File: rtl/wa_prio.sv
module wa_prio #(
  parameter int N = 4,
  localparam int PW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] prio_o
);
  import wa_pkg::*;

  logic [PW-1:0] prio_d;

  assign prio_d = PW'(prio_succ(int'(prio_o), N));

  always_ff @(posedge clk) begin
    if (!rst_n) prio_o <= '0;
    else        prio_o <= prio_d;
  end
endmodule

// File: rtl/wa_array.sv
// Token array laid out by (hop, row) rather than (row, column): hop 0 is
// the priority diagonal, so the wrap-around loop is already cut and the
// chain of N hops is acyclic.
module wa_array #(
  parameter int N = 4,
  localparam int NN = N * N
) (
  input  logic [NN-1:0] want_i,   // bit r*N+h : row r at hop h
  output logic [NN-1:0] win_o     // same layout
);
  for (genvar h = 0; h < N; h++) begin : g_hop
    logic [N-1:0] row_in, col_in, row_out, col_out;

    if (h == 0) begin : g_inject
      assign row_in = '1;
      assign col_in = '1;
    end else begin : g_pass
      // Row token stays in its row; column token drops to the next row,
      // so row r receives what row r-1 (wrapping) released one hop earlier.
      assign row_in = g_hop[h-1].row_out;
      if (N > 1) begin : g_rot
        assign col_in = {g_hop[h-1].col_out[N-2:0], g_hop[h-1].col_out[N-1]};
      end else begin : g_one
        assign col_in = g_hop[h-1].col_out;
      end
    end

    for (genvar r = 0; r < N; r++) begin : g_row
      wa_cell i_cell (
        .want_i    (want_i[r*N+h]),
        .row_tok_i (row_in[r]),
        .col_tok_i (col_in[r]),
        .win_o     (win_o[r*N+h]),
        .row_tok_o (row_out[r]),
        .col_tok_o (col_out[r])
      );
    end
  end
endmodule

// File: rtl/wave_alloc.sv
module wave_alloc #(
  parameter int N = 4,
  localparam int NN = N * N,
  localparam int PW = $clog2(N),
  localparam int IW = $clog2(NN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NN-1:0] req_i,
  output logic [NN-1:0] gnt_o
);
  import wa_pkg::*;

  logic [PW-1:0] prio_q;
  logic [NN-1:0] want_hop;   // requests re-indexed by (row, hop)
  logic [NN-1:0] win_hop;    // grants in (row, hop) order

  wa_prio #(.N(N)) i_prio (
    .clk    (clk),
    .rst_n  (rst_n),
    .prio_o (prio_q)
  );

  // Gather: hop h of row r looks at the column the row token reaches.
  for (genvar r = 0; r < N; r++) begin : g_gather_row
    for (genvar h = 0; h < N; h++) begin : g_gather_hop
      logic [IW-1:0] src;
      always_comb src = IW'(r * N + step_to_col(r, h, int'(prio_q), N));
      assign want_hop[r*N+h] = req_i[src];
    end
  end

  wa_array #(.N(N)) i_array (
    .want_i (want_hop),
    .win_o  (win_hop)
  );

  // Scatter: column c of row r is served by the hop that reached it.
  for (genvar r = 0; r < N; r++) begin : g_scatter_row
    for (genvar c = 0; c < N; c++) begin : g_scatter_col
      logic [IW-1:0] src;
      always_comb src = IW'(r * N + col_to_step(r, c, int'(prio_q), N));
      assign gnt_o[r*N+c] = win_hop[src];
    end
  end
endmodule

// File: rtl/wa_checker.sv
module wa_checker #(
  parameter int N = 4,
  localparam int NN = N * N,
  localparam int PW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NN-1:0] req_i,
  input logic [NN-1:0] gnt_o,
  input logic [PW-1:0] prio_q
);
  logic [N-1:0] row_busy;
  logic [N-1:0] col_busy;

  for (genvar r = 0; r < N; r++) begin : g_rows
    assign row_busy[r] = |gnt_o[r*N +: N];
    assert_one_per_row_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o[r*N +: N]));
  end

  for (genvar c = 0; c < N; c++) begin : g_cols
    logic [N-1:0] col_vec;
    for (genvar r = 0; r < N; r++) begin : g_bit
      assign col_vec[r] = gnt_o[r*N+c];
    end
    assign col_busy[c] = |col_vec;
    assert_one_per_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col_vec));
  end

  assert_grant_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o & ~req_i) == '0);

  for (genvar r = 0; r < N; r++) begin : g_cells_r
    for (genvar c = 0; c < N; c++) begin : g_cells_c
      assert_maximal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_i[r*N+c] && !row_busy[r] && !col_busy[c]));
      assert_diag_served_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_q == PW'((r + c) % N)) && req_i[r*N+c] |-> gnt_o[r*N+c]);
    end
  end

  assert_prio_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (prio_q == PW'(0) && $past(prio_q) == PW'(N-1)) ||
              (prio_q == $past(prio_q) + PW'(1)));
endmodule

bind wave_alloc wa_checker #(.N(N)) i_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .req_i  (req_i),
  .gnt_o  (gnt_o),
  .prio_q (prio_q)
);

// File: tb/test_wave_alloc.sv
`timescale 1ns/1ps
module test_wave_alloc;
  localparam int N  = 4;
  localparam int NN = N * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NN-1:0] req = '0;
  logic [NN-1:0] gnt;
  int            model_p = 0;
  int            checks = 0;
  int            errors = 0;

  always #5 clk = ~clk;

  wave_alloc #(.N(N)) i_wave_alloc (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (req),
    .gnt_o (gnt)
  );

  // Bench copy of the pointer: counts edges seen with reset released.
  always @(posedge clk) model_p <= rst_n ? (model_p + 1) % N : 0;

  // Token model: one liveness flag per row and per column, diagonals
  // visited in order starting at the pointer.
  function automatic logic [NN-1:0] model_grant(logic [NN-1:0] r, int p);
    logic [NN-1:0] g = '0;
    bit row_live [N];
    bit col_live [N];
    for (int k = 0; k < N; k++) begin row_live[k] = 1; col_live[k] = 1; end
    for (int s = 0; s < N; s++)
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if ((i + j) % N == (p + s) % N && r[i*N+j] && row_live[i] && col_live[j]) begin
            g[i*N+j] = 1'b1;
            row_live[i] = 0;
            col_live[j] = 0;
          end
    return g;
  endfunction

  function automatic logic [NN-1:0] diag_mask(int p);
    logic [NN-1:0] m = '0;
    for (int i = 0; i < N; i++) m[i*N + (p + N - i) % N] = 1'b1;
    return m;
  endfunction

  task automatic expect_eq(string tag, logic [NN-1:0] act, logic [NN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: p=%0d req=%h actual=%h expected=%h", tag, model_p, req, act, exp);
    end
  endtask

  task automatic check_props();
    logic [N-1:0] rb = '0, cb = '0;
    int bad1 = 0, bad2 = 0, bad4 = 0;
    for (int i = 0; i < N; i++) begin
      int cnt = 0;
      for (int j = 0; j < N; j++) cnt += int'(gnt[i*N+j]);
      if (cnt > 1) bad1++;
      rb[i] = (cnt != 0);
    end
    for (int j = 0; j < N; j++) begin
      int cnt = 0;
      for (int i = 0; i < N; i++) cnt += int'(gnt[i*N+j]);
      if (cnt > 1) bad2++;
      cb[j] = (cnt != 0);
    end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (req[i*N+j] && !rb[i] && !cb[j]) bad4++;
    checks += 4;
    if (bad1 != 0) begin errors++; $display("FAIL R1: rows with >1 grant actual=%0d expected=0", bad1); end
    if (bad2 != 0) begin errors++; $display("FAIL R2: cols with >1 grant actual=%0d expected=0", bad2); end
    if ((gnt & ~req) != '0) begin errors++; $display("FAIL R3: unrequested grants actual=%h expected=0", gnt & ~req); end
    if (bad4 != 0) begin errors++; $display("FAIL R4: free requesting cells actual=%0d expected=0", bad4); end
  endtask

  task automatic apply(logic [NN-1:0] v);
    @(negedge clk);
    req = v;
    #1;
    expect_eq("R6", gnt, model_grant(v, model_p));
    check_props();
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: run did not complete actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NN-1:0] ex;
    // R7: reset holds the pointer on diagonal 0 across several edges.
    req = '1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    expect_eq("R7 reset diagonal", gnt, diag_mask(0));

    // R7: worked example on the first cycle after release (pointer 0).
    ex = '0;
    ex[0*N+0] = 1'b1; ex[0*N+1] = 1'b1; ex[0*N+2] = 1'b1;
    ex[1*N+0] = 1'b1; ex[1*N+1] = 1'b1;
    ex[2*N+0] = 1'b1;
    ex[3*N+0] = 1'b1; ex[3*N+2] = 1'b1;
    req = ex;
    rst_n = 1'b1;
    #1;
    begin
      logic [NN-1:0] want = '0;
      want[0*N+0] = 1'b1; want[1*N+1] = 1'b1; want[3*N+2] = 1'b1;
      expect_eq("R7 example", gnt, want);
    end

    // R8 and R5: all-ones request exposes the pointer as the granted diagonal.
    for (int k = 0; k < 3 * N; k++) begin
      @(negedge clk);
      req = '1;
      #1;
      expect_eq("R8 pointer diagonal", gnt, diag_mask(model_p));
      expect_eq("R5 diagonal served", gnt & diag_mask(model_p), diag_mask(model_p));
    end

    // R9-style single requests: one lone request is always granted (R4/R6).
    for (int b = 0; b < NN; b++) apply(NN'(1) << b);

    // Exhaustive sweep of every request pattern against the token model (R6).
    for (int v = 0; v < (1 << NN); v++) apply(NN'(v));

    // Reset in mid-run returns the pointer to 0 (R7).
    @(negedge clk);
    rst_n = 1'b0;
    req = '1;
    @(negedge clk); #1;
    expect_eq("R7 re-reset", gnt, diag_mask(0));
    rst_n = 1'b1;
    #1;
    apply('1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule